// File: doc/BRIEF.md
# Low-Speed USB Packet Transmitter

This block serializes one packet onto the D+/D- pair of a low-speed USB port. The bit period is eight clock cycles. A start strobe launches a packet. The block then owns the line: it enables the drivers, holds idle J for one bit time, and sends a sync byte. After the sync byte it sends the buffered bytes, least-significant bit first. The line is NRZI coded, and a stuffed bit follows every run of six ones.

After the last bit the block sends end of packet: two bit times of SE0, then one bit time of J. It then drops the output enable and pulses done. While the enable is low, both lines are driven low, so no pull-up is left active.

The sync byte is generated inside the block. The byte count gives the packet length with sync included, so a handshake reply uses a count of 2. The remaining bytes are read from an external buffer through an address/data port. The address for the next byte is held for a whole byte time before that byte is needed. CRC and packet content are decided elsewhere.

Top module: `usb_ls_tx`

## Requirements
- R1: After reset, oe_o, dp_o, dm_o and done_o are all 0.
- R2: A start_i pulse is accepted only while the block is idle and byte_cnt_i is not 0. From the next cycle oe_o is 1 and the line shows J for exactly 8 cycles before the first sync bit.
- R3: Line states are encoded as J = (dp_o 0, dm_o 1), K = (dp_o 1, dm_o 0) and SE0 = both 0. dp_o and dm_o are never both 1, and both are 0 whenever oe_o is 0.
- R4: Every bit, stuffed bits included, lasts exactly 8 cycles, and the line changes only on bit boundaries.
- R5: The first byte sent is 0x80. It is followed by byte_cnt_i-1 buffer bytes read from rd_addr_o = 0, 1, 2, and so on. Each byte is sent LSB first. rd_data_i may arrive up to 7 cycles after rd_addr_o changes.
- R6: NRZI coding: a data 0 toggles the line and a data 1 holds it.
- R7: After six consecutive 1 bits, one extra toggle is inserted and the run count restarts. The run carries across byte boundaries, a trailing run of six ones is stuffed before end of packet, and the run count is clear at the start of sync.
- R8: After the last bit (and any trailing stuffed bit), the line shows SE0 for 16 cycles, then J for 8 cycles, then oe_o falls.
- R9: done_o is a single-cycle pulse in the cycle oe_o first reads 0 after a packet.
- R10: A start_i pulse while a packet is in progress has no effect on the line.
- R11: A start_i pulse with byte_cnt_i = 0 is ignored and the line stays released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, 8 cycles per bit |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Packet launch strobe |
| byte_cnt_i | input | CNT_W | Packet length in bytes, sync included |
| rd_data_i | input | 8 | Buffer byte at rd_addr_o |
| rd_addr_o | output | CNT_W | Buffer address of the next byte |
| dp_o | output | 1 | D+ level |
| dm_o | output | 1 | D- level |
| oe_o | output | 1 | Line driver enable |
| done_o | output | 1 | Pulse on bus release |

## Verification
The assertions check these on every cycle:
- the line encoding rules: no SE1, and both lines low while released;
- that every line change falls on the eight-cycle bit grid;
- that the line is never held for more than seven bit times, which would mean a missed stuff;
- that each packet opens on J;
- that done_o is a single pulse on release.

Only the bench's reference comparison shows the rest:
- the bit order;
- the NRZI content;
- where stuffed bits fall, both across byte boundaries and at the end of a packet;
- the exact length of end of packet;
- that starts while busy and starts with a zero count are ignored.

// File: rtl/usb_ls_tx_pkg.sv
package usb_ls_tx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LEAD,
    ST_DATA,
    ST_SE0,
    ST_TAIL
  } tx_state_e;

  localparam logic [7:0] SYNC_BYTE = 8'h80;
endpackage

// File: rtl/usb_ls_bit_timer.sv
module usb_ls_bit_timer #(
  parameter int BIT_CYC = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic clr_i,
  output logic tick_o
);
  localparam int PH_W = (BIT_CYC > 1) ? $clog2(BIT_CYC) : 1;
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(BIT_CYC - 1);

  logic [PH_W-1:0] ph_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              ph_q <= '0;
    else if (clr_i)           ph_q <= '0;
    else if (ph_q == PH_LAST) ph_q <= '0;
    else                      ph_q <= ph_q + 1'b1;
  end

  assign tick_o = run_i && (ph_q == PH_LAST);
endmodule

// File: rtl/usb_ls_byte_feed.sv
module usb_ls_byte_feed #(
  parameter int CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             adv_i,
  input  logic [7:0]       rd_data_i,
  output logic             bit_o,
  output logic             empty_o,
  output logic [CNT_W-1:0] rd_addr_o
);
  import usb_ls_tx_pkg::*;

  logic [7:0]       sh_q;
  logic [2:0]       bidx_q;
  logic [CNT_W-1:0] left_q;
  logic [CNT_W-1:0] addr_q;
  logic             empty_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q    <= '0;
      bidx_q  <= '0;
      left_q  <= '0;
      addr_q  <= '0;
      empty_q <= 1'b1;
    end else if (load_i) begin
      sh_q    <= SYNC_BYTE;
      bidx_q  <= '0;
      left_q  <= cnt_i - CNT_W'(1);
      addr_q  <= '0;
      empty_q <= 1'b0;
    end else if (adv_i) begin
      if (bidx_q == 3'd7) begin
        // address held since the previous byte load, data long settled
        if (left_q != '0) begin
          sh_q   <= rd_data_i;
          bidx_q <= '0;
          left_q <= left_q - 1'b1;
          addr_q <= addr_q + 1'b1;
        end else begin
          empty_q <= 1'b1;
        end
      end else begin
        bidx_q <= bidx_q + 1'b1;
      end
    end
  end

  assign bit_o     = sh_q[bidx_q];
  assign empty_o   = empty_q;
  assign rd_addr_o = addr_q;
endmodule

// File: rtl/usb_ls_line_enc.sv
module usb_ls_line_enc #(
  parameter int STUFF_RUN = 6
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_j_i,
  input  logic send_i,
  input  logic bit_i,
  output logic line_k_o,
  output logic stuff_due_o
);
  localparam int RUN_W = $clog2(STUFF_RUN + 1);

  logic [RUN_W-1:0] run_q;
  logic             line_k_q;

  assign stuff_due_o = (run_q == RUN_W'(STUFF_RUN));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      line_k_q <= 1'b0;
      run_q    <= '0;
    end else if (set_j_i) begin
      line_k_q <= 1'b0;
      run_q    <= '0;
    end else if (send_i) begin
      if (stuff_due_o || !bit_i) begin
        line_k_q <= ~line_k_q;
        run_q    <= '0;
      end else begin
        run_q    <= run_q + 1'b1;
      end
    end
  end

  assign line_k_o = line_k_q;
endmodule

// File: rtl/usb_ls_tx.sv
module usb_ls_tx #(
  parameter int BIT_CYC   = 8,
  parameter int CNT_W     = 4,
  parameter int SE0_BITS  = 2,
  parameter int STUFF_RUN = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [CNT_W-1:0] byte_cnt_i,
  input  logic [7:0]       rd_data_i,
  output logic [CNT_W-1:0] rd_addr_o,
  output logic             dp_o,
  output logic             dm_o,
  output logic             oe_o,
  output logic             done_o
);
  import usb_ls_tx_pkg::*;

  localparam int EOP_W = (SE0_BITS > 1) ? $clog2(SE0_BITS) : 1;
  localparam logic [EOP_W-1:0] EOP_LAST = EOP_W'(SE0_BITS - 1);

  tx_state_e        state_q;
  logic             oe_q, se0_q, done_q;
  logic [EOP_W-1:0] eop_q;

  logic tick, start_acc, send, adv, set_j, eop_last;
  logic cur_bit, empty, line_k, stuff_due;

  assign start_acc = (state_q == ST_IDLE) && start_i && (byte_cnt_i != '0);
  assign eop_last  = (eop_q == EOP_LAST);
  assign send      = tick && ((state_q == ST_LEAD) ||
                     ((state_q == ST_DATA) && (stuff_due || !empty)));
  assign adv       = send && !stuff_due;
  assign set_j     = start_acc || ((state_q == ST_SE0) && tick && eop_last);

  usb_ls_bit_timer #(.BIT_CYC(BIT_CYC)) u_tmr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (state_q != ST_IDLE),
    .clr_i  (start_acc),
    .tick_o (tick)
  );

  usb_ls_byte_feed #(.CNT_W(CNT_W)) u_feed (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (start_acc),
    .cnt_i     (byte_cnt_i),
    .adv_i     (adv),
    .rd_data_i (rd_data_i),
    .bit_o     (cur_bit),
    .empty_o   (empty),
    .rd_addr_o (rd_addr_o)
  );

  usb_ls_line_enc #(.STUFF_RUN(STUFF_RUN)) u_enc (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .set_j_i     (set_j),
    .send_i      (send),
    .bit_i       (cur_bit),
    .line_k_o    (line_k),
    .stuff_due_o (stuff_due)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      oe_q    <= 1'b0;
      se0_q   <= 1'b0;
      done_q  <= 1'b0;
      eop_q   <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_acc) begin
          state_q <= ST_LEAD;
          oe_q    <= 1'b1;
          se0_q   <= 1'b0;
        end
        ST_LEAD: if (tick) state_q <= ST_DATA;
        // trailing stuff bit goes out before SE0
        ST_DATA: if (tick && !stuff_due && empty) begin
          state_q <= ST_SE0;
          se0_q   <= 1'b1;
          eop_q   <= '0;
        end
        ST_SE0: if (tick) begin
          if (eop_last) begin
            state_q <= ST_TAIL;
            se0_q   <= 1'b0;
          end else begin
            eop_q <= eop_q + 1'b1;
          end
        end
        ST_TAIL: if (tick) begin
          state_q <= ST_IDLE;
          oe_q    <= 1'b0;
          done_q  <= 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign dp_o   = oe_q && !se0_q && line_k;
  assign dm_o   = oe_q && !se0_q && !line_k;
  assign oe_o   = oe_q;
  assign done_o = done_q;
endmodule

// File: rtl/usb_ls_tx_chk.sv
module usb_ls_tx_chk #(
  parameter int BIT_CYC = 8
) (
  input logic clk_i,
  input logic rst_ni,
  input logic dp_o,
  input logic dm_o,
  input logic oe_o,
  input logic done_o
);
  localparam int PH_W = (BIT_CYC > 1) ? $clog2(BIT_CYC) : 1;

  logic            oe_d;
  logic [1:0]      ln_d;
  logic [PH_W-1:0] ph;
  logic [3:0]      hold;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      oe_d <= 1'b0;
      ln_d <= '0;
      ph   <= '0;
      hold <= '0;
    end else begin
      oe_d <= oe_o;
      ln_d <= {dp_o, dm_o};
      if (!oe_o || ph == PH_W'(BIT_CYC - 1)) ph <= '0;
      else ph <= ph + 1'b1;
      if (!oe_o) hold <= '0;
      else if (ph == '0) begin
        if (!oe_d || {dp_o, dm_o} != ln_d) hold <= 4'd1;
        else if (hold != 4'hf) hold <= hold + 1'b1;
      end
    end
  end

  AST_NO_SE1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(dp_o && dm_o)); // R3
  AST_IDLE_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !oe_o |-> (!dp_o && !dm_o)); // R3
  AST_LEAD_J: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (oe_o && !oe_d) |-> (!dp_o && dm_o)); // R2
  AST_BIT_GRID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (oe_o && oe_d && ({dp_o, dm_o} != ln_d)) |-> (ph == '0)); // R4
  AST_STUFF_LIMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_o |-> (hold <= 4'd7)); // R7
  AST_DONE_AT_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!oe_o && oe_d)); // R9
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R9
endmodule

bind usb_ls_tx usb_ls_tx_chk #(.BIT_CYC(BIT_CYC)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .dp_o   (dp_o),
  .dm_o   (dm_o),
  .oe_o   (oe_o),
  .done_o (done_o)
);

// File: tb/tb_usb_ls_tx.sv
module tb_usb_ls_tx;
  localparam int BIT_CYC = 8;
  localparam int CNT_W   = 4;

  logic             clk = 1'b0;
  logic             rst_ni;
  logic             start;
  logic [CNT_W-1:0] byte_cnt;
  logic [7:0]       rd_data;
  logic [CNT_W-1:0] rd_addr;
  logic             dp, dm, oe, done;

  logic [7:0] mem [16];
  logic [3:0] exp_q [$];
  string      tag_q [$];
  string      idle_tag = "R3";
  int         checks = 0;
  int         errors = 0;

  always #2 clk = ~clk;

  // buffer with one cycle of read latency
  always @(posedge clk) rd_data <= mem[rd_addr];

  usb_ls_tx #(.BIT_CYC(BIT_CYC), .CNT_W(CNT_W)) dut (
    .clk_i      (clk),
    .rst_ni     (rst_ni),
    .start_i    (start),
    .byte_cnt_i (byte_cnt),
    .rd_data_i  (rd_data),
    .rd_addr_o  (rd_addr),
    .dp_o       (dp),
    .dm_o       (dm),
    .oe_o       (oe),
    .done_o     (done)
  );

  task automatic push_n(input logic [3:0] v, input int n, input string t);
    for (int i = 0; i < n; i++) begin
      exp_q.push_back(v);
      tag_q.push_back(t);
    end
  endtask

  // expected per-cycle {oe,dp,dm,done} for a packet of n bytes incl. sync
  task automatic expect_pkt(input int n, input string ovr);
    int         lv;
    int         run;
    logic [7:0] b;
    logic [3:0] v;
    lv = 0;
    run = 0;
    push_n(4'b1010, BIT_CYC, (ovr != "") ? ovr : "R2");
    for (int k = 0; k < n; k++) begin
      b = (k == 0) ? 8'h80 : mem[k-1];
      for (int i = 0; i < 8; i++) begin
        if (b[i] == 1'b0) begin lv ^= 1; run = 0; end
        else run++;
        v = {1'b1, lv[0], ~lv[0], 1'b0};
        push_n(v, BIT_CYC, (ovr != "") ? ovr : "R4 R5 R6");
        if (run == 6) begin
          lv ^= 1;
          run = 0;
          v = {1'b1, lv[0], ~lv[0], 1'b0};
          push_n(v, BIT_CYC, (ovr != "") ? ovr : "R4 R7");
        end
      end
    end
    push_n(4'b1000, 2 * BIT_CYC, (ovr != "") ? ovr : "R8");
    push_n(4'b1010, BIT_CYC, (ovr != "") ? ovr : "R8");
    push_n(4'b0001, 1, (ovr != "") ? ovr : "R9");
  endtask

  always @(negedge clk) begin
    logic [3:0] act, exp_v;
    string      t;
    if (rst_ni) begin
      act = {oe, dp, dm, done};
      if (exp_q.size() != 0) begin
        exp_v = exp_q.pop_front();
        t = tag_q.pop_front();
      end else begin
        exp_v = 4'b0000;
        t = idle_tag;
      end
      checks++;
      if (act !== exp_v) begin
        errors++;
        $display("FAIL %s: {oe,dp,dm,done} got %b expected %b", t, act, exp_v);
      end
    end
  end

  task automatic run_pkt(input int n, input bit busy_poke);
    @(negedge clk); #1;
    start = 1'b1;
    byte_cnt = CNT_W'(n);
    expect_pkt(n, busy_poke ? "R10" : "");
    @(negedge clk); #1;
    start = 1'b0;
    if (busy_poke) begin
      repeat (40) @(negedge clk);
      #1;
      start = 1'b1;
      byte_cnt = CNT_W'(3);
      @(negedge clk); #1;
      start = 1'b0;
    end
    while (exp_q.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  task automatic report;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: got timeout expected completion");
    report();
  end

  initial begin
    rst_ni = 1'b0;
    start = 1'b0;
    byte_cnt = '0;
    for (int i = 0; i < 16; i++) mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    checks++;
    if ({oe, dp, dm, done} !== 4'b0000) begin
      errors++;
      $display("FAIL R1: reset outputs got %b expected 0000", {oe, dp, dm, done});
    end
    #1 rst_ni = 1'b1;
    repeat (3) @(negedge clk);

    // handshake: sync + PID
    mem[0] = 8'hD2;
    run_pkt(2, 1'b0);

    // mixed data bytes
    mem[0] = 8'hC3; mem[1] = 8'h01; mem[2] = 8'h02; mem[3] = 8'h55; mem[4] = 8'hAA;
    run_pkt(6, 1'b0);

    // R7: ones run across byte boundary
    mem[0] = 8'hFF; mem[1] = 8'hFF; mem[2] = 8'h7E;
    run_pkt(4, 1'b0);

    // R7: trailing six ones, stuff before EOP
    mem[0] = 8'h00; mem[1] = 8'hFC;
    run_pkt(3, 1'b0);

    // R10: start while busy
    mem[0] = 8'h3C; mem[1] = 8'hF0; mem[2] = 8'h81; mem[3] = 8'h18;
    run_pkt(5, 1'b1);

    // R11: zero count start
    idle_tag = "R11";
    @(negedge clk); #1;
    start = 1'b1;
    byte_cnt = '0;
    @(negedge clk); #1;
    start = 1'b0;
    repeat (30) @(negedge clk);
    idle_tag = "R3";

    // R5: longest packet, distinct bytes
    for (int i = 0; i < 16; i++) mem[i] = 8'(i * 37 + 5);
    run_pkt(15, 1'b0);

    report();
  end
endmodule